// File: doc/BRIEF.md
# Supply Supervisor Watchdog Reset Controller

This block is the digital core of a supply supervisor that also watches a processor through a watchdog. A comparator outside the block reports whether the supply is above its detect threshold, as a synchronous supply-good flag. Whenever that flag is false, the block pulls its active-low reset output down. Once the flag is true again, the reset is held for a coded release delay before it is freed.

While the supply is good and the watchdog is enabled, the processor must toggle a kick input within a coded timeout. Either edge counts as a kick. After each accepted edge, further edges are ignored for a short blanking window. If no edge arrives in time, the block issues a reset of the release-delay length. The watchdog then starts timing again from zero.

An enable input, whose active level is set by a parameter, switches off the watchdog alone. All durations are counted in pulses of a one-cycle tick input. A parameter gives the number of ticks per millisecond.

Top module: `wdog_supervisor`

## Requirements
- R1: `reset_n` is 0 while `rst_n` is low. In the cycle after any clock edge at which `supply_ok` is 0, `reset_n` is 0.
- R2: With `supply_ok` held at 1, a low `reset_n` returns to 1 after the edge that counts the release-delay number of tick pulses. The count runs from the first edge at which `supply_ok` is 1.
- R3: Release code `rel_code` selects the delay: 0 gives floor(3.13 ms × TICKS_PER_MS) ticks, 1 gives 50 ms, 2 gives 100 ms, 3 gives 200 ms, and 4 to 7 give 400 ms.
- R4: Timeout code `tmo_code` selects the watchdog period as 50 ms × 2^(code−2) for codes 2 to 7. Codes 0 and 1 behave as code 2.
- R5: After a two-flop synchroniser, a rising or a falling edge of `kick` restarts the watchdog count from zero.
- R6: If no edge is accepted for a full timeout while the watchdog is armed, `reset_n` drops. It stays low for the release delay, then rises, and the timeout count starts afresh.
- R7: With `kick` constant, resets repeat with a fall-to-fall period of timeout plus release delay, in tick pulses.
- R8: An accepted kick edge opens a blanking window of floor(BLANK_US × TICKS_PER_MS / 1000) ticks. Edges inside that window do not restart the count.
- R9: While the watchdog is disabled, no watchdog reset occurs. Supply loss still forces reset, and the release delay still applies.
- R10: Enabling the watchdog while the supply is good and `reset_n` is high causes no reset pulse. The timeout starts from zero.
- R11: Parameter EN_ACTIVE_HIGH=1 means `wd_en`=1 enables the watchdog. EN_ACTIVE_HIGH=0 means `wd_en`=0 enables it.
- R12: `cfg_err` is 1 in any of three cases: `tmo_code` is below 2, `rel_code` is above 4, or the release delay is longer than the timeout. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| supply_ok | input | 1 | Synchronous supply-good flag |
| kick | input | 1 | Watchdog kick, asynchronous |
| wd_en | input | 1 | Watchdog enable, polarity by EN_ACTIVE_HIGH |
| tmo_code | input | 3 | Watchdog timeout code |
| rel_code | input | 3 | Release delay code |
| reset_n | output | 1 | Active-low reset output |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The assertions assume that `supply_ok` is already clean and synchronous to `clk`, and that `tick` is a single-cycle pulse. The bench drives every input half a cycle away from the sampling edge. It produces `tick` from a divider that runs every cycle or every third cycle. The codes change only between scenarios, so that each measured pulse length comes from one configuration. A second instance with the opposite enable polarity receives the inverted enable, and both instances must track the same reference model.

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int TICKS_PER_MS   = 100,
  parameter int BLANK_US       = 900,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       kick,
  input  logic       wd_en,
  input  logic [2:0] tmo_code,
  input  logic [2:0] rel_code,
  output logic       reset_n,
  output logic       cfg_err
);
  localparam int CNT_W       = $clog2(1600 * TICKS_PER_MS + 1);
  localparam int BLANK_TICKS = (BLANK_US * TICKS_PER_MS) / 1000;
  localparam int BLK_W       = $clog2(BLANK_TICKS + 2);
  localparam int REL_MIN     = (313 * TICKS_PER_MS) / 100;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] tmo_ticks, rel_ticks, wd_cnt, rel_cnt;
  logic [BLK_W-1:0] blank_cnt;
  logic [2:0]       kick_sr;
  logic [1:0]       en_sr;
  logic             wd_on, armed, kick_edge, kick_take, expire, rel_done;

  always_comb begin
    case (tmo_code)
      3'd3:    tmo_ticks = CNT_W'(100 * TICKS_PER_MS);
      3'd4:    tmo_ticks = CNT_W'(200 * TICKS_PER_MS);
      3'd5:    tmo_ticks = CNT_W'(400 * TICKS_PER_MS);
      3'd6:    tmo_ticks = CNT_W'(800 * TICKS_PER_MS);
      3'd7:    tmo_ticks = CNT_W'(1600 * TICKS_PER_MS);
      default: tmo_ticks = CNT_W'(50 * TICKS_PER_MS);
    endcase
    case (rel_code)
      3'd0:    rel_ticks = CNT_W'(REL_MIN);
      3'd1:    rel_ticks = CNT_W'(50 * TICKS_PER_MS);
      3'd2:    rel_ticks = CNT_W'(100 * TICKS_PER_MS);
      3'd3:    rel_ticks = CNT_W'(200 * TICKS_PER_MS);
      default: rel_ticks = CNT_W'(400 * TICKS_PER_MS);
    endcase
  end

  assign cfg_err = (tmo_code < 3'd2) | (rel_code > 3'd4) | (rel_ticks > tmo_ticks);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kick_sr <= '0;
      en_sr   <= '0;
    end else begin
      kick_sr <= {kick_sr[1:0], kick};
      en_sr   <= {en_sr[0], wd_en};
    end

  assign wd_on     = EN_ACTIVE_HIGH ? en_sr[1] : ~en_sr[1];
  assign kick_edge = kick_sr[2] ^ kick_sr[1];
  assign armed     = supply_ok & reset_n & wd_on;
  assign kick_take = armed & kick_edge & (blank_cnt == '0);
  assign expire    = armed & tick & ~kick_take & (wd_cnt >= tmo_ticks - ONE);
  assign rel_done  = supply_ok & ~reset_n & tick & (rel_cnt >= rel_ticks - ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              reset_n <= 1'b0;
    else if (!supply_ok)     reset_n <= 1'b0;
    else if (expire)         reset_n <= 1'b0;
    else if (rel_done)       reset_n <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    rel_cnt <= '0;
    else if (!supply_ok || reset_n) rel_cnt <= '0;
    else if (tick)                 rel_cnt <= rel_done ? '0 : rel_cnt + ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 wd_cnt <= '0;
    else if (!armed || kick_take) wd_cnt <= '0;
    else if (tick)              wd_cnt <= expire ? '0 : wd_cnt + ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         blank_cnt <= '0;
    else if (!armed)                    blank_cnt <= '0;
    else if (kick_take)                 blank_cnt <= BLK_W'(BLANK_TICKS);
    else if (tick && blank_cnt != '0)   blank_cnt <= blank_cnt - BLK_W'(1);
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             supply_ok,
  input logic [2:0]       tmo_code,
  input logic [2:0]       rel_code,
  input logic             reset_n,
  input logic             cfg_err,
  input logic             wd_on,
  input logic             kick_take,
  input logic [CNT_W-1:0] wd_cnt
);
  AST_SUPPLY_LOSS_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !reset_n); // R1
  AST_RELEASE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> ($past(tick) && $past(supply_ok))); // R2
  AST_KICK_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    kick_take |=> (wd_cnt == '0)); // R5
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_n) |-> (!$past(supply_ok) || $past(wd_on))); // R6
  AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n && supply_ok && !wd_on) |=> reset_n); // R9
  AST_LONG_RELEASE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_code == 3'd4 && tmo_code == 3'd2) |-> cfg_err); // R12
  AST_BAD_TIMEOUT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_code < 3'd2) |-> cfg_err); // R12
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
  .tmo_code(tmo_code), .rel_code(rel_code), .reset_n(reset_n), .cfg_err(cfg_err),
  .wd_on(wd_on), .kick_take(kick_take), .wd_cnt(wd_cnt)
);

// File: tb/test_wdog_supervisor.sv
module test_wdog_supervisor;
  localparam int TPM = 4;
  localparam int BLK = (900 * TPM) / 1000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, supply_ok = 1'b0, kick = 1'b0, en = 1'b1;
  logic [2:0] tmo_code = 3'd2, rel_code = 3'd0;
  logic rst_hi, rst_lo, err_hi, err_lo;
  int checks = 0, failures = 0, cyc = 0, tick_div = 1, tick_cnt = 0;
  int n_falls = 0, fall_cyc = 0, prev_fall = 0, rise_cyc = 0;
  string cur_req = "R1";
  logic last_rst = 1'b0;

  always #5 clk = ~clk;

  wdog_supervisor #(.TICKS_PER_MS(TPM), .EN_ACTIVE_HIGH(1'b1)) i_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .kick(kick), .wd_en(en),
    .tmo_code(tmo_code), .rel_code(rel_code), .reset_n(rst_hi), .cfg_err(err_hi));
  wdog_supervisor #(.TICKS_PER_MS(TPM), .EN_ACTIVE_HIGH(1'b0)) i_wdog_supervisor_n (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .kick(kick), .wd_en(~en),
    .tmo_code(tmo_code), .rel_code(rel_code), .reset_n(rst_lo), .cfg_err(err_lo));

  function automatic int tmo_t(int c);
    return (c < 2) ? 50 * TPM : (50 * TPM) << (c - 2);
  endfunction
  function automatic int rel_t(int c);
    if (c == 0) return (313 * TPM) / 100;
    if (c >= 4) return 400 * TPM;
    return (50 * TPM) << (c - 1);
  endfunction
  function automatic bit cfg_t(int t, int r);
    return (t < 2) || (r > 4) || (rel_t(r) > tmo_t(t));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // reference model: integer timers, kick and enable history in queues
  int m_rst = 0, m_rel = 0, m_wd = 0, m_blk = 0;
  int khist[$] = '{0, 0, 0};
  int ehist[$] = '{0, 0};

  always @(posedge clk) begin
    int nxt, won, edge_seen, armed, take, T, R;
    if (rst_n) begin
      checks++;
      if (err_hi !== cfg_t(tmo_code, rel_code) || err_lo !== cfg_t(tmo_code, rel_code)) begin
        failures++;
        $display("FAIL R12 act=%0d/%0d exp=%0d", err_hi, err_lo, cfg_t(tmo_code, rel_code));
      end
    end
    if (!rst_n) begin
      m_rst = 0; m_rel = 0; m_wd = 0; m_blk = 0;
      khist = '{0, 0, 0}; ehist = '{0, 0};
    end else begin
      T = tmo_t(tmo_code); R = rel_t(rel_code);
      won = ehist[1];
      edge_seen = (khist[1] != khist[2]);
      armed = supply_ok && m_rst && won;
      take = armed && edge_seen && (m_blk == 0);
      nxt = m_rst;
      if (!supply_ok) begin
        nxt = 0; m_rel = 0;
      end else if (!m_rst && tick) begin
        if (m_rel + 1 >= R) begin nxt = 1; m_rel = 0; end
        else m_rel++;
      end
      if (!armed) begin
        m_wd = 0; m_blk = 0;
      end else if (take) begin
        m_wd = 0; m_blk = BLK;
      end else if (tick) begin
        if (m_wd + 1 >= T) begin nxt = 0; m_wd = 0; end
        else m_wd++;
        if (m_blk > 0) m_blk--;
      end
      m_rst = nxt;
      khist.push_front(int'(kick)); void'(khist.pop_back());
      ehist.push_front(int'(en));   void'(ehist.pop_back());
    end
  end

  always @(negedge clk) begin
    cyc++;
    tick_cnt = (tick_cnt + 1) % tick_div;
    tick <= (tick_cnt == 0);
    if (rst_n) begin
      checks++;
      if (rst_hi !== m_rst[0] || rst_lo !== m_rst[0]) begin
        failures++;
        $display("FAIL %s act=%0d/%0d exp=%0d", cur_req, rst_hi, rst_lo, m_rst);
      end
      if (last_rst && !rst_hi) begin n_falls++; prev_fall = fall_cyc; fall_cyc = cyc; end
      if (!last_rst && rst_hi) rise_cyc = cyc;
      last_rst = rst_hi;
    end
  end

  task automatic wait_falls(int n);
    int target = n_falls + n;
    for (int i = 0; i < 20000 && n_falls < target; i++) run(1);
  endtask
  task automatic wait_high();
    for (int i = 0; i < 20000 && !rst_hi; i++) run(1);
  endtask

  initial begin
    int f0;
    fork
      begin
        run(150000);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    run(4);
    chk("R1 reset state", int'(rst_hi) + int'(rst_lo), 0);
    rst_n = 1'b1;
    run(30);
    chk("R1 supply low", int'(rst_hi) + int'(rst_lo), 0);

    cur_req = "R2";
    supply_ok = 1'b1;
    run(11);
    chk("R2 before delay", int'(rst_hi), 0);
    run(1);
    chk("R3 code0 released", int'(rst_hi) + int'(rst_lo), 2);

    cur_req = "R5";
    f0 = n_falls;
    for (int i = 0; i < 20; i++) begin run(60); kick = ~kick; end
    chk("R5 kicked no reset", n_falls, f0);

    cur_req = "R6";
    wait_falls(1);
    wait_high();
    chk("R3 code0 low length", rise_cyc - fall_cyc, rel_t(0));
    chk("R6 released after expiry", int'(rst_hi), 1);

    cur_req = "R4";
    tmo_code = 3'd3;
    wait_falls(2);
    chk("R4 R7 period code3", fall_cyc - prev_fall, tmo_t(3) + rel_t(0));

    cur_req = "R3";
    rel_code = 3'd2; tmo_code = 3'd5;
    wait_falls(1);
    wait_high();
    chk("R3 code2 low length", rise_cyc - fall_cyc, rel_t(2));

    cur_req = "R8";
    rel_code = 3'd0; tmo_code = 3'd2;
    wait_falls(1);
    wait_high();
    f0 = n_falls;
    for (int i = 0; i < 8; i++) begin
      run(120); kick = ~kick; run(2); kick = ~kick;
    end
    chk("R8 pairs keep alive", n_falls, f0);
    run(1); kick = ~kick; run(1); kick = ~kick;
    run(3); kick = ~kick; run(2); kick = ~kick;
    wait_falls(1);
    wait_high();

    cur_req = "R9";
    en = 1'b0;
    f0 = n_falls;
    run(1500);
    chk("R9 disabled no trip", n_falls, f0);
    supply_ok = 1'b0;
    run(5);
    chk("R9 supply still monitored", int'(rst_hi) + int'(rst_lo), 0);
    supply_ok = 1'b1;
    run(30);
    chk("R9 release while disabled", int'(rst_hi) + int'(rst_lo), 2);

    cur_req = "R10";
    en = 1'b1;
    f0 = n_falls;
    run(150);
    chk("R10 no pulse on enable", n_falls, f0);
    chk("R11 both polarities high", int'(rst_hi) + int'(rst_lo), 2);
    run(100);
    chk("R11 watchdog active after enable", n_falls, f0 + 1);

    cur_req = "R7";
    tick_div = 3; rel_code = 3'd1; tmo_code = 3'd3;
    wait_falls(2);
    chk("R7 period slow tick", fall_cyc - prev_fall, 3 * (tmo_t(3) + rel_t(1)));

    tick_div = 1;
    tmo_code = 3'd2; rel_code = 3'd4; run(1);
    chk("R12 400 over 50", int'(err_hi), 1);
    tmo_code = 3'd5; run(1);
    chk("R12 equal is legal", int'(err_hi), 0);
    tmo_code = 3'd1; run(1);
    chk("R12 bad timeout code", int'(err_hi), 1);
    tmo_code = 3'd7; rel_code = 3'd6; run(1);
    chk("R12 bad release code", int'(err_lo), 1);
    rel_code = 3'd0; run(1);
    chk("R12 short release legal", int'(err_lo), 0);

    run(50);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule